// File: doc/BRIEF.md
# Software SMI Countdown Timer

This block is a one-shot countdown timer that raises a system management interrupt request a programmable time after software arms it. The arming bit lives in a control register owned by the parent. The timer only watches that bit as a level. A 2-bit rate select picks one of four parameterised tick counts, and a prescaled tick pulse from elsewhere drives the count.

When the armed count runs out, the timer sets a sticky status flag and emits a single-cycle SMI request in the same clock. The enable is not cleared by the timer. It stays high until software drops it, and a fresh countdown begins only after the enable goes low and then high again. Dropping the enable before expiry cancels the count silently. The status flag is cleared by a write-one-to-clear strobe.

Top module: `swsmi_timer`

## Requirements
- R1: After synchronous reset, `tmr_sts` and `smi_req` are 0.
- R2: A countdown starts on the first clock edge that samples `tmr_en` high while the timer is idle. A tick sampled on that same edge is not counted. `smi_req` and `tmr_sts` are both 1 right after the edge that samples the N-th later tick, where N is the selected count.
- R3: The count N follows `rate_sel` as 2'b00 → `TICKS_0`, 2'b01 → `TICKS_1`, 2'b10 → `TICKS_2`, 2'b11 → `TICKS_3`. Each count must be at least 1.
- R4: If `tmr_en` is sampled low before expiry, no SMI is produced. A later raise of `tmr_en` starts a full new count.
- R5: Each expiry gives exactly one `smi_req` pulse, one cycle wide.
- R6: While `tmr_en` stays high after expiry, further ticks produce no SMI. Only a low-then-high sequence on `tmr_en` restarts the timer.
- R7: `tmr_sts` stays 1 until a `sts_clr` strobe, and it reads 0 after the edge that samples the strobe.
- R8: A `sts_clr` sampled on the same edge as an expiry leaves `tmr_sts` at 1.
- R9: A change of `rate_sel` during a countdown does not alter that countdown. The new value applies at the next start.
- R10: Ticks sampled while `tmr_en` is low have no effect. No SMI follows them, and the next start still counts a full N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Enable level from the parent control register |
| rate_sel | input | 2 | Timeout select, latched at start |
| tick | input | 1 | Prescaled time-base pulse, one cycle wide |
| sts_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| tmr_sts | output | 1 | Sticky expiry status |
| smi_req | output | 1 | Single-cycle SMI request |

## Verification
A wrong latched count or a missed decrement moves the SMI pulse to an earlier or later tick. The monitor sees this on the very cycle the pulse appears, or fails to appear, against the queued expected edge. A state machine that does not hold its done state, or does not cancel on a low enable, shows up as an unexpected pulse on the next tick the bench drives. A status flag with the wrong priority shows up at the port one cycle after the clear strobe or after the expiry.

// File: rtl/swsmi_pkg.sv
package swsmi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } swsmi_state_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/swsmi_rate_mux.sv
module swsmi_rate_mux #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned TICKS_0 = 3,
  parameter int unsigned TICKS_1 = 5,
  parameter int unsigned TICKS_2 = 8,
  parameter int unsigned TICKS_3 = 12
) (
  input  logic [1:0]       rate_sel,
  output logic [CNT_W-1:0] load_val
);
  localparam int unsigned NUM_RATES = 4;
  localparam int unsigned TBL [NUM_RATES] = '{TICKS_0, TICKS_1, TICKS_2, TICKS_3};

  logic [CNT_W-1:0] tbl_w [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tbl
    assign tbl_w[g] = CNT_W'(TBL[g]);
  end

  assign load_val = tbl_w[rate_sel];

  always_comb begin
    a_r3_nonzero_count: assert (load_val != '0);
  end
endmodule

// File: rtl/swsmi_cnt_core.sv
module swsmi_cnt_core
  import swsmi_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire_now,
  output logic             smi_pulse
);
  swsmi_state_e     st;
  logic [CNT_W-1:0] cnt;

  assign expire_now = en && (st == ST_RUN) && tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      smi_pulse <= 1'b0;
    end else begin
      smi_pulse <= expire_now;
      if (!en) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          ST_IDLE: begin
            st  <= ST_RUN;
            cnt <= load_val;
          end
          ST_RUN: begin
            if (tick) begin
              if (cnt == CNT_W'(1)) begin
                st  <= ST_DONE;
                cnt <= '0;
              end else begin
                cnt <= cnt - CNT_W'(1);
              end
            end
          end
          default: st <= ST_DONE;
        endcase
      end
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    smi_pulse |=> !smi_pulse);
  a_r4_cancel_no_smi: assert property (@(posedge clk) disable iff (rst)
    !en |=> !smi_pulse);
  a_r6_hold_done: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE) && en |=> (st == ST_DONE));
  a_r2_run_nonzero: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> (cnt != '0));
  a_r9_count_holds: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) && en && !tick |=> $stable(cnt));
endmodule

// File: rtl/swsmi_sts_reg.sv
module swsmi_sts_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  always_ff @(posedge clk) begin
    if (rst)        sts_o <= 1'b0;
    else if (set_i) sts_o <= 1'b1;
    else if (clr_i) sts_o <= 1'b0;
  end

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    sts_o && !clr_i |=> sts_o);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> sts_o);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i && !set_i |=> !sts_o);
endmodule

// File: rtl/swsmi_timer.sv
module swsmi_timer
  import swsmi_pkg::*;
#(
  parameter int unsigned TICKS_0 = 3,
  parameter int unsigned TICKS_1 = 5,
  parameter int unsigned TICKS_2 = 8,
  parameter int unsigned TICKS_3 = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tmr_en,
  input  logic [1:0] rate_sel,
  input  logic       tick,
  input  logic       sts_clr,
  output logic       tmr_sts,
  output logic       smi_req
);
  localparam int unsigned MAX_TICKS = max4(TICKS_0, TICKS_1, TICKS_2, TICKS_3);
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] load_val;
  logic             expire_now;

  swsmi_rate_mux #(
    .CNT_W(CNT_W), .TICKS_0(TICKS_0), .TICKS_1(TICKS_1),
    .TICKS_2(TICKS_2), .TICKS_3(TICKS_3)
  ) u_mux (
    .rate_sel(rate_sel),
    .load_val(load_val)
  );

  swsmi_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .en        (tmr_en),
    .tick      (tick),
    .load_val  (load_val),
    .expire_now(expire_now),
    .smi_pulse (smi_req)
  );

  swsmi_sts_reg u_sts (
    .clk  (clk),
    .rst  (rst),
    .set_i(expire_now),
    .clr_i(sts_clr),
    .sts_o(tmr_sts)
  );

  a_r2_smi_with_sts: assert property (@(posedge clk) disable iff (rst)
    smi_req |-> tmr_sts);
endmodule

// File: tb/tb_swsmi_timer.sv
module tb_swsmi_timer;
  localparam int N0 = 3, N1 = 5, N2 = 8, N3 = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic tmr_en = 1'b0, tick = 1'b0, sts_clr = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic tmr_sts, smi_req;

  int cyc = 0, n_chk = 0, n_bad = 0;
  int exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  swsmi_timer #(.TICKS_0(N0), .TICKS_1(N1), .TICKS_2(N2), .TICKS_3(N3)) dut (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .rate_sel(rate_sel),
    .tick(tick), .sts_clr(sts_clr), .tmr_sts(tmr_sts), .smi_req(smi_req)
  );

  // Monitor: compares each SMI pulse with the queued expected edge.
  always @(posedge clk) begin
    #2;
    if (!rst && smi_req) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5/R6: unexpected smi_req at cycle %0d, expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          n_bad++;
          $display("FAIL R2: smi_req at cycle %0d, expected %0d", cyc, e);
        end
      end
    end else if (!rst && exp_q.size() != 0 && exp_q[0] < cyc) begin
      int e;
      e = exp_q.pop_front();
      n_chk++; n_bad++;
      $display("FAIL R2: smi_req missing, actual none by %0d, expected %0d", cyc, e);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drives n ticks with one idle cycle between; optionally the last expires.
  task automatic ticks(input int n, input bit expire_last, input bit clr_last);
    for (int i = 1; i <= n; i++) begin
      step(1);
      tick = 1'b1;
      if (i == n && clr_last) sts_clr = 1'b1;
      if (i == n && expire_last) exp_q.push_back(cyc + 1);
      step(1);
      tick = 1'b0;
      sts_clr = 1'b0;
    end
    step(2);
  endtask

  task automatic clear_sts();
    sts_clr = 1'b1; step(1); sts_clr = 1'b0; step(1);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 sts", tmr_sts, 1'b0);
    chk("R1 smi", smi_req, 1'b0);

    // R2/R3: rate 00
    rate_sel = 2'b00; tmr_en = 1'b1; step(1);
    ticks(N0, 1'b1, 1'b0);
    chk("R2 sts after expiry", tmr_sts, 1'b1);
    // R5/R6: enable held high, more ticks give no SMI
    ticks(6, 1'b0, 1'b0);
    chk("R6 no restart", smi_req, 1'b0);
    // R7: sticky then cleared
    step(5);
    chk("R7 sticky", tmr_sts, 1'b1);
    clear_sts();
    chk("R7 cleared", tmr_sts, 1'b0);

    // R3/R9: rate 01, switch to 11 mid-count
    tmr_en = 1'b0; step(2);
    rate_sel = 2'b01; tmr_en = 1'b1; step(1);
    ticks(2, 1'b0, 1'b0);
    rate_sel = 2'b11;
    ticks(N1 - 2, 1'b1, 1'b0);
    chk("R9 expiry at old rate", tmr_sts, 1'b1);
    clear_sts();

    // R4: cancel mid-count, R10: ticks while low ignored
    tmr_en = 1'b0; step(2);
    rate_sel = 2'b10; tmr_en = 1'b1; step(1);
    ticks(N2 - 1, 1'b0, 1'b0);
    tmr_en = 1'b0; step(1);
    ticks(4, 1'b0, 1'b0);
    chk("R4 cancelled no sts", tmr_sts, 1'b0);
    chk("R10 low ticks no smi", smi_req, 1'b0);
    tmr_en = 1'b1; step(1);
    ticks(N2 - 1, 1'b0, 1'b0);
    chk("R4 full recount", tmr_sts, 1'b0);
    ticks(1, 1'b1, 1'b0);
    chk("R3 rate 10 expiry", tmr_sts, 1'b1);
    clear_sts();

    // R8: clear coincident with expiry, rate 11
    tmr_en = 1'b0; step(2);
    rate_sel = 2'b11; tmr_en = 1'b1; step(1);
    ticks(N3 - 1, 1'b0, 1'b0);
    ticks(1, 1'b1, 1'b1);
    chk("R8 set beats clear", tmr_sts, 1'b1);
    tmr_en = 1'b0;
    step(4);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: pending expected pulses actual %0d expected 0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule